// File: doc/BRIEF.md
# Registered ALU Status Flag Generator

This block sits beside an integer ALU and turns one finished operation into six status flags: carry, overflow, zero, parity, adjust (the nibble carry) and sign. It takes the two operands, the carry or borrow the ALU consumed, the operation type and the ALU's result. It does not redo the arithmetic. The carry into every bit position is recovered as operand A XOR effective operand B XOR result, where the effective B is inverted for subtraction. Carry, overflow and adjust come from those recovered adder carries. Zero, parity and sign are taken from the finished result.

The flags are held in one register stage. They appear on the clock edge after the operation is presented, together with a valid strobe. The block has no stall and no back-pressure, so a new operation is accepted every cycle, including a run of dependent operations. The data width is a parameter with a default of 32 bits and a minimum of 8.

Top module: `flag_gen`

## Requirements
- R1: While reset is low, `out_vld` and all six flags are 0, and they stay 0 on the first edge after reset is released.
- R2: An operation with `in_vld` high on a clock edge puts its flags on the outputs after that edge, and `out_vld` goes high in the same cycle. A cycle with `in_vld` low leaves every flag unchanged and drives `out_vld` low. Operations may arrive on consecutive cycles.
- R3: The operation code `op` selects the operation: 000 add, 001 add with carry, 010 subtract, 011 subtract with borrow, 1xx any logical operation. For the arithmetic codes, `cin` is the carry or borrow that the ALU used.
- R4: For add and add-with-carry, the carry flag is the carry out of the most significant bit of the unsigned sum a+b(+cin).
- R5: For subtract and subtract-with-borrow, the carry flag is the borrow: it is set exactly when a-b(-cin) is negative as an unsigned difference. This is the inverted adder carry-out.
- R6: For the arithmetic codes, the overflow flag is the XOR of the carry into the top bit and the carry out of the top bit. It is set exactly when the signed two's-complement result falls outside the representable range.
- R7: The zero flag is set exactly when all W bits of the result are 0.
- R8: The parity flag is set exactly when bits 7..0 of the result hold an even number of ones. Bits above 7 are ignored.
- R9: The adjust flag is the carry out of bit 3 for addition. For subtraction it is the borrow out of bit 3, which is the inverted adder carry.
- R10: The sign flag equals the top bit of the result.
- R11: For logical operations (`op[2]`=1), the carry, overflow and adjust flags are 0. Zero, parity and sign still follow the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | An ALU operation is presented this cycle |
| op | input | 3 | Operation code (see R3) |
| opa | input | W | First ALU operand |
| opb | input | W | Second ALU operand |
| cin | input | 1 | Carry or borrow consumed by the ALU |
| res | input | W | ALU result |
| out_vld | output | 1 | Flags below belong to the operation of the previous cycle |
| flag_c | output | 1 | Carry / borrow |
| flag_o | output | 1 | Signed overflow |
| flag_z | output | 1 | Result is zero |
| flag_p | output | 1 | Even parity of the low result byte |
| flag_a | output | 1 | Nibble carry / borrow |
| flag_s | output | 1 | Result sign |

## Verification
The hardest cases to reach are those where only the incoming carry or borrow decides an outcome. Two examples: a subtract-with-borrow whose top-bit carry flips overflow but not borrow, and a nibble borrow caused by the borrow-in alone. An 8-bit configuration is swept over every operand pair for add and subtract, and over a dense grid for the carry-consuming forms, with the carry-in alternating across the grid, so these cases arise many times. A second, 16-bit instance shows two things: a zero low byte with a non-zero upper byte, which separates the full-width zero test from the byte-wide parity test, and a signed overflow at bit 15.

// File: rtl/flag_gen.sv
module flag_gen #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [2:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  input  logic [W-1:0] res,
  output logic         out_vld,
  output logic         flag_c,
  output logic         flag_o,
  output logic         flag_z,
  output logic         flag_p,
  output logic         flag_a,
  output logic         flag_s
);

  logic         is_logic, is_sub;
  logic [W-1:0] bx, cvec;
  logic         c_top_in, c_top_out;
  logic         nxt_c, nxt_o, nxt_a, nxt_z, nxt_p, nxt_s;

  assign is_logic  = op[2];
  assign is_sub    = op[1] & ~op[2];
  assign bx        = is_sub ? ~opb : opb;
  assign cvec      = opa ^ bx ^ res;
  assign c_top_in  = cvec[W-1];
  assign c_top_out = (opa[W-1] & bx[W-1]) | (c_top_in & (opa[W-1] ^ bx[W-1]));

  assign nxt_c = is_logic ? 1'b0 : (c_top_out ^ is_sub);
  assign nxt_o = is_logic ? 1'b0 : (c_top_in ^ c_top_out);
  assign nxt_a = is_logic ? 1'b0 : (cvec[4] ^ is_sub);
  assign nxt_z = ~|res;
  assign nxt_p = ~^res[7:0];
  assign nxt_s = res[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      {flag_c, flag_o, flag_z, flag_p, flag_a, flag_s} <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld)
        {flag_c, flag_o, flag_z, flag_p, flag_a, flag_s} <=
          {nxt_c, nxt_o, nxt_z, nxt_p, nxt_a, nxt_s};
    end
  end

  assert_cin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !op[2]) |-> (cvec[0] == (op[0] ? (cin ^ op[1]) : op[1])));

  assert_vld_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable({flag_c, flag_o, flag_z, flag_p, flag_a, flag_s}) && !out_vld));

  assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (flag_z == ($past(res) == '0)));

  assert_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (flag_p == ($countones($past(res[7:0])) % 2 == 0)));

  assert_sign_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (flag_s == $past(res[W-1])));

  assert_logic_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op[2]) |=> (!flag_c && !flag_o && !flag_a));

endmodule

// File: tb/sim_flag_gen.sv
module sim_flag_gen;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, vld, ci;
  logic [2:0] op;
  logic [7:0] a, b, r;
  logic       ov, fc, fo, fz, fp, fa, fs;

  logic        vld1;
  logic [15:0] a1, b1, r1;
  logic        ov1, fc1, fo1, fz1, fp1, fa1, fs1;

  int checks = 0;
  int errors = 0;
  bit ec, eo, ez, ep, ea, es;

  flag_gen #(.W(8)) u0 (.clk(clk), .rst_n(rst_n), .in_vld(vld), .op(op),
    .opa(a), .opb(b), .cin(ci), .res(r), .out_vld(ov),
    .flag_c(fc), .flag_o(fo), .flag_z(fz), .flag_p(fp), .flag_a(fa), .flag_s(fs));

  flag_gen #(.W(16)) u1 (.clk(clk), .rst_n(rst_n), .in_vld(vld1), .op(3'b000),
    .opa(a1), .opb(b1), .cin(1'b0), .res(r1), .out_vld(ov1),
    .flag_c(fc1), .flag_o(fo1), .flag_z(fz1), .flag_p(fp1), .flag_a(fa1), .flag_s(fs1));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b (op=%0d a=%0h b=%0h ci=%0b)", tag, act, exp, op, a, b, ci);
    end
  endtask

  task automatic run(input logic [2:0] o, input int ia, input int ib, input bit ic);
    int full, sa, sb, sr, icc, ones;
    logic [7:0] rr;
    sa  = ia > 127 ? ia - 256 : ia;
    sb  = ib > 127 ? ib - 256 : ib;
    icc = o[0] ? int'(ic) : 0;
    eo = 0; ec = 0; ea = 0;
    if (o == 3'd0 || o == 3'd1) begin
      full = ia + ib + icc; rr = full[7:0];
      ec = full > 255; sr = sa + sb + icc; eo = (sr > 127) || (sr < -128);
      ea = (ia % 16 + ib % 16 + icc) > 15;
    end else if (o == 3'd2 || o == 3'd3) begin
      full = ia - ib - icc; rr = full[7:0];
      ec = full < 0; sr = sa - sb - icc; eo = (sr > 127) || (sr < -128);
      ea = (ia % 16 - ib % 16 - icc) < 0;
    end else if (o == 3'd4) rr = ia[7:0] & ib[7:0];
    else if (o == 3'd5)     rr = ia[7:0] | ib[7:0];
    else                    rr = ia[7:0] ^ ib[7:0];
    ones = 0;
    for (int k = 0; k < 8; k++) ones += int'(rr[k]);
    ez = (rr == 8'd0); ep = (ones % 2 == 0); es = rr[7];
    op = o; a = ia[7:0]; b = ib[7:0]; r = rr; ci = ic; vld = 1'b1;
    @(negedge clk);
    chk("R2 out_vld", ov, 1'b1);
    chk(o[2] ? "R11 carry" : (o[1] ? "R5 borrow" : "R4 carry"), fc, ec);
    chk(o[2] ? "R11 overflow" : "R6 overflow", fo, eo);
    chk(o[2] ? "R11 adjust" : "R9 adjust", fa, ea);
    chk("R7 zero", fz, ez);
    chk("R8 parity", fp, ep);
    chk("R10 sign", fs, es);
  endtask

  task automatic run16(input int ia, input int ib, input bit xc, input bit xo,
                       input bit xz, input bit xp, input bit xa, input bit xs);
    int full;
    full = ia + ib;
    a1 = ia[15:0]; b1 = ib[15:0]; r1 = full[15:0]; vld1 = 1'b1;
    @(negedge clk);
    vld1 = 1'b0;
    chk("R4 carry w16", fc1, xc);
    chk("R6 overflow w16", fo1, xo);
    chk("R7 zero full width", fz1, xz);
    chk("R8 parity low byte", fp1, xp);
    chk("R9 adjust w16", fa1, xa);
    chk("R10 sign w16", fs1, xs);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vld = 1'b0; op = 3'd0; a = 8'hFF; b = 8'hFF; r = 8'h00; ci = 1'b1;
    vld1 = 1'b0; a1 = '0; b1 = '0; r1 = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset vld", ov, 1'b0);
    chk("R1 reset flags", |{fc, fo, fz, fp, fa, fs}, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", |{ov, fc, fo, fz, fp, fa, fs}, 1'b0);

    for (int ia = 0; ia < 256; ia++)
      for (int ib = 0; ib < 256; ib++) run(3'd0, ia, ib, 1'b0);
    for (int ia = 0; ia < 256; ia++)
      for (int ib = 0; ib < 256; ib++) run(3'd2, ia, ib, 1'b0);
    for (int ia = 0; ia < 256; ia++)
      for (int ib = 0; ib < 256; ib += 5) run(3'd1, ia, ib, bit'((ia ^ ib) & 1));
    for (int ia = 0; ia < 256; ia++)
      for (int ib = 0; ib < 256; ib += 5) run(3'd3, ia, ib, bit'((ia ^ ib ^ 1) & 1));
    for (int ia = 0; ia < 256; ia++)
      for (int ib = 0; ib < 256; ib += 37) begin
        run(3'd4, ia, ib, 1'b1);
        run(3'd5, ia, ib, 1'b1);
        run(3'd6, ia, ib, 1'b1);
      end

    run(3'd2, 8'h10, 8'h01, 1'b0);
    vld = 1'b0; a = 8'h00; b = 8'h00; r = 8'h00; op = 3'd0;
    repeat (3) @(negedge clk);
    chk("R2 idle vld low", ov, 1'b0);
    chk("R2 hold carry", fc, ec);
    chk("R2 hold zero", fz, ez);
    chk("R2 hold adjust", fa, ea);
    chk("R2 hold parity", fp, ep);

    run16(16'h00FF, 16'h0001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    run16(16'hFFFF, 16'h0001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    run16(16'h7FFF, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);

    run(3'd0, 8'h7F, 8'h01, 1'b0);
    rst_n = 1'b0; vld = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", |{ov, fc, fo, fz, fp, fa, fs}, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule